// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Bank

This block holds the interrupt state of an I2C controller. Twelve event sources arrive from the controller datapath, either as single-cycle pulses or, for the two FIFO-threshold sources, as levels. Pulse sources are latched and stay set until software clears them. A writable enable mask selects which latched sources reach the single interrupt line. The mask can also be read back, and the bank exposes both the unmasked and the masked view of the sources.

Software clears sources by reading, not by writing. Each source has a clear address of its own, and reading it clears that one source. A separate global clear address clears every latched source in one read. Alongside the transfer-abort source, the bank keeps a cause register that records why a transfer aborted. That register is wiped by the same read that clears the abort source, so software has to read the cause first. All accesses go through a plain register port with a registered read return.

Top module: `i2c_irq_regbank`

## Requirements
- R1: A pulse on `evt_in[b]` for a sticky source sets bit b of the raw view (offset 2). The bit positions are: 0 rx underflow, 1 rx overflow, 2 rx threshold, 3 tx overflow, 4 tx threshold, 5 read request, 6 transfer abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R2: A read of offset 1 returns the raw view ANDed with the mask register. The mask is written and read at offset 0. A write to any other offset is ignored.
- R3: A read of offset 5+b returns the raw view as it was before the read and clears sticky bit b only.
- R4: A read of offset 4 clears every sticky raw bit and the abort-cause register.
- R5: The abort-cause register (offset 3) accumulates `abrt_cause_in` bits by OR. It is cleared by the read of offset 11, which is the clear address of source 6, and that read also clears raw bit 6.
- R6: With the mask at zero the interrupt output stays low, and the raw view is unchanged.
- R7: Bits 2 and 4 follow `evt_in[2]` and `evt_in[4]` one cycle late, and a clear read has no effect on them.
- R8: When an event pulse arrives in the same cycle as a clear read of that source, the bit stays set.
- R9: `irq` is the OR of all masked bits, registered: it rises in the cycle after the raw bit is set.
- R10: After reset the raw view, mask, abort cause and `irq` are all zero.
- R11: The abort-cause bits that are kept are 0, 1, 2, 3, 4, 5, 7, 9, 10 and 11. Input bits 6 and 8 are never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | N_SRC | Event pulses (sticky sources) or levels (threshold sources) |
| abrt_cause_in | input | N_SRC | Abort-cause bits, ORed into the cause register |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read return strobe, one cycle after reg_rd |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the bank with its defaults: twelve sources, a five-bit offset space, threshold sources at bits 2 and 4, and abort at bit 6. With these values every clear offset up to 16, the level-versus-sticky split and the dropped cause bits 6 and 8 can all be reached directly. A reference model in the bench tracks the raw, mask and cause state. Every read return is checked against that model, including reads issued in the same cycle as a colliding event pulse.

// File: rtl/i2c_irq_pkg.sv
// Package: word offsets of the interrupt bank register port.
// Assumes: clear offsets for source b sit at OFS_CLR_BASE + b.
package i2c_irq_pkg;
    localparam int unsigned OFS_MASK     = 0;
    localparam int unsigned OFS_MASKED   = 1;
    localparam int unsigned OFS_RAW      = 2;
    localparam int unsigned OFS_CAUSE    = 3;
    localparam int unsigned OFS_CLR_ALL  = 4;
    localparam int unsigned OFS_CLR_BASE = 5;
endpackage

// File: rtl/irq_src_latch.sv
// Module: one raw status cell. The LEVEL variant registers the input level
// and ignores clears. The sticky variant sets on a pulse and clears on clr.
// Assumes: evt has priority over clr in the same cycle.
module irq_src_latch #(
    parameter bit LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic q
);
    generate
        if (LEVEL) begin : g_level
            logic unused_clr;
            assign unused_clr = clr;
            // Track the threshold level one cycle late.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= evt;
            end
        end else begin : g_sticky
            // Hold until cleared; a new event beats a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= 1'b0;
                else if (evt) q <= 1'b1;
                else if (clr) q <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_abort_cause.sv
// Module: accumulates abort-cause bits. Only the bits enabled in KEEP are stored.
// Assumes: new cause bits arriving with a clear are retained.
module irq_abort_cause #(
    parameter int unsigned        W    = 12,
    parameter logic [W-1:0]       KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_in,
    input  logic         clr,
    output logic [W-1:0] cause_q
);
    logic [W-1:0] cause_kept;
    assign cause_kept = cause_in & KEEP;

    // OR new bits in; a clear drops the old bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)   cause_q <= '0;
        else if (clr) cause_q <= cause_kept;
        else          cause_q <= cause_q | cause_kept;
    end
endmodule

// File: rtl/irq_reg_port.sv
// Module: register port decode. It produces the read-to-clear strobes and
// the mask write enable, and a registered read return.
// Assumes: a clear offset returns the raw view sampled before the clear.
module irq_reg_port
    import i2c_irq_pkg::*;
#(
    parameter int unsigned N_SRC    = 12,
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned ABRT_IDX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  raw,
    input  logic [N_SRC-1:0]  mask,
    input  logic [N_SRC-1:0]  cause,
    output logic [N_SRC-1:0]  clr_vec,
    output logic              clr_cause,
    output logic              mask_we,
    output logic [N_SRC-1:0]  rdata_q,
    output logic              rvalid_q
);
    localparam int unsigned CLR_END = OFS_CLR_BASE + N_SRC;

    int unsigned  addr_i;
    logic         hit_all;
    logic [N_SRC-1:0] rd_sel;

    assign addr_i  = int'(addr);
    assign hit_all = rd && (addr_i == OFS_CLR_ALL);
    assign mask_we = wr && (addr_i == OFS_MASK);

    genvar b;
    generate
        for (b = 0; b < N_SRC; b++) begin : g_clr
            // Per-source clear strobe, or the global one.
            assign clr_vec[b] = hit_all || (rd && (addr_i == OFS_CLR_BASE + b));
        end
    endgenerate

    assign clr_cause = clr_vec[ABRT_IDX];

    // Select the read data for the addressed offset.
    always_comb begin
        if      (addr_i == OFS_MASK)   rd_sel = mask;
        else if (addr_i == OFS_MASKED) rd_sel = raw & mask;
        else if (addr_i == OFS_RAW)    rd_sel = raw;
        else if (addr_i == OFS_CAUSE)  rd_sel = cause;
        else if (addr_i >= OFS_CLR_ALL && addr_i < CLR_END) rd_sel = raw;
        else                           rd_sel = '0;
    end

    // Register the read return and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd;
            if (rd) rdata_q <= rd_sel;
        end
    end
endmodule

// File: rtl/i2c_irq_regbank.sv
// Module: I2C interrupt status and clear bank (top). Raw latches, the enable
// mask, abort-cause capture and a registered interrupt output.
// Assumes: event generation and bus fabric sit outside this block.
module i2c_irq_regbank #(
    parameter int unsigned           N_SRC     = 12,
    parameter int unsigned           ADDR_W    = 5,
    parameter int unsigned           ABRT_IDX  = 6,
    parameter logic [N_SRC-1:0]      LEVEL_SRC = 12'h014,
    parameter logic [N_SRC-1:0]      ABRT_KEEP = 12'hEBF,
    parameter logic [N_SRC-1:0]      MASK_RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  evt_in,
    input  logic [N_SRC-1:0]  abrt_cause_in,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N_SRC-1:0]  reg_wdata,
    output logic [N_SRC-1:0]  reg_rdata,
    output logic              reg_rvalid,
    output logic              irq
);
    logic [N_SRC-1:0] raw_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] cause_q;
    logic [N_SRC-1:0] clr_vec;
    logic             clr_cause;
    logic             mask_we;

    genvar b;
    generate
        for (b = 0; b < N_SRC; b++) begin : g_src
            irq_src_latch #(.LEVEL(LEVEL_SRC[b])) u_latch (
                .clk (clk),
                .rst_n(rst_n),
                .evt (evt_in[b]),
                .clr (clr_vec[b]),
                .q   (raw_q[b])
            );
        end
    endgenerate

    irq_abort_cause #(.W(N_SRC), .KEEP(ABRT_KEEP)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_in(abrt_cause_in),
        .clr     (clr_cause),
        .cause_q (cause_q)
    );

    irq_reg_port #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .ABRT_IDX(ABRT_IDX)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (reg_rd),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .raw      (raw_q),
        .mask     (mask_q),
        .cause    (cause_q),
        .clr_vec  (clr_vec),
        .clr_cause(clr_cause),
        .mask_we  (mask_we),
        .rdata_q  (reg_rdata),
        .rvalid_q (reg_rvalid)
    );

    // Mask register, written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= MASK_RST;
        else if (mask_we) mask_q <= reg_wdata;
    end

    // Interrupt line: OR of the masked bits, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(raw_q & mask_q);
    end
endmodule

// File: rtl/i2c_irq_regbank_chk.sv
// Module: property checker for the interrupt bank, bound to the top.
// Assumes: default offsets from i2c_irq_pkg.
module i2c_irq_regbank_chk
    import i2c_irq_pkg::*;
#(
    parameter int unsigned      N_SRC     = 12,
    parameter int unsigned      ADDR_W    = 5,
    parameter logic [N_SRC-1:0] LEVEL_SRC = 12'h014,
    parameter logic [N_SRC-1:0] ABRT_KEEP = 12'hEBF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  evt_in,
    input logic [N_SRC-1:0]  abrt_cause_in,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [N_SRC-1:0]  raw_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  cause_q,
    input logic              irq
);
    localparam logic [N_SRC-1:0] STICKY = ~LEVEL_SRC;

    logic [N_SRC-1:0] stk_evt;
    assign stk_evt = evt_in & STICKY;

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|stk_evt) |=> ((raw_q & $past(stk_evt)) == $past(stk_evt))); // R8

    AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(OFS_CLR_ALL) && stk_evt == '0 && abrt_cause_in == '0)
        |=> ((raw_q & STICKY) == '0 && cause_q == '0)); // R4

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq); // R6

    AST_CAUSE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & ~ABRT_KEEP) == '0); // R11

    genvar b;
    generate
        for (b = 0; b < N_SRC; b++) begin : g_chk
            if (STICKY[b]) begin : g_stk
                AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                    (reg_rd && reg_addr == ADDR_W'(OFS_CLR_BASE + b) && !evt_in[b])
                    |=> !raw_q[b]); // R3
            end
        end
    endgenerate
endmodule

bind i2c_irq_regbank i2c_irq_regbank_chk #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .LEVEL_SRC(LEVEL_SRC), .ABRT_KEEP(ABRT_KEEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .abrt_cause_in(abrt_cause_in),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .raw_q(raw_q), .mask_q(mask_q),
    .cause_q(cause_q), .irq(irq)
);

// File: tb/test_i2c_irq_regbank.sv
// Scoreboard bench: read tasks push expected values, a monitor pops and compares.
module test_i2c_irq_regbank;
    localparam int unsigned N = 12;
    localparam int unsigned AW = 5;
    localparam logic [N-1:0] LVL  = 12'h014;
    localparam logic [N-1:0] KEEP = 12'hEBF;
    localparam int CLR_ALL = 4;
    localparam int CLR_B   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] evt_in = '0;
    logic [N-1:0] abrt_cause_in = '0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic reg_rvalid, irq;

    int n_chk = 0, n_fail = 0;
    logic [N-1:0] m_raw = '0, m_mask = '0, m_cause = '0, lvl = '0;
    logic [N-1:0] exp_q[$];
    string req_q[$];

    always #2.5 clk = ~clk;

    i2c_irq_regbank i_i2c_irq_regbank (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .abrt_cause_in(abrt_cause_in),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_read(input int a);
        if (a == 0) return m_mask;
        if (a == 1) return m_raw & m_mask;
        if (a == 2) return m_raw;
        if (a == 3) return m_cause;
        if (a >= CLR_ALL && a < CLR_B + int'(N)) return m_raw;
        return '0;
    endfunction

    function automatic void model_clear(input int a);
        if (a == CLR_ALL) begin
            m_raw = m_raw & LVL;
            m_cause = '0;
        end else if (a >= CLR_B && a < CLR_B + int'(N)) begin
            if (!LVL[a-CLR_B]) m_raw[a-CLR_B] = 1'b0;
            if (a - CLR_B == 6) m_cause = '0;
        end
    endfunction

    // Read with an optional colliding event pulse in the same cycle.
    task automatic rd_pulse(input int a, input logic [N-1:0] bits, input string req);
        exp_q.push_back(model_read(a));
        req_q.push_back(req);
        model_clear(a);
        m_raw = m_raw | (bits & ~LVL);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = AW'(a); evt_in = bits | lvl;
        @(negedge clk);
        reg_rd = 1'b0; evt_in = lvl;
    endtask

    task automatic rd(input int a, input string req);
        rd_pulse(a, '0, req);
    endtask

    task automatic pulse(input logic [N-1:0] bits, input logic [N-1:0] cause);
        @(negedge clk);
        evt_in = bits | lvl; abrt_cause_in = cause;
        @(negedge clk);
        evt_in = lvl; abrt_cause_in = '0;
        m_raw = m_raw | (bits & ~LVL);
        m_cause = m_cause | (cause & KEEP);
    endtask

    task automatic set_lvl(input logic [N-1:0] v);
        @(negedge clk);
        lvl = v; evt_in = v;
        @(negedge clk);
        m_raw = (m_raw & ~LVL) | (v & LVL);
    endtask

    task automatic wr_reg(input int a, input logic [N-1:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 0) m_mask = v;
    endtask

    task automatic chk_irq(input string req);
        repeat (2) @(negedge clk);
        check(req, {11'd0, irq}, {11'd0, |(m_raw & m_mask)});
    endtask

    // Monitor: compare each read return against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            if (reg_rvalid) begin
                if (exp_q.size() == 0) check("R2 unexpected read", reg_rdata, '0);
                else check(req_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10 irq", {11'd0, irq}, '0);
        rd(2, "R10 raw");
        rd(0, "R10 mask");
        rd(3, "R10 cause");
        // R1: every sticky bit position
        pulse(12'hFEB, '0);
        rd(2, "R1 raw bits");
        // R2: masked view, write to a read-only offset ignored
        wr_reg(0, 12'h0F0);
        wr_reg(2, 12'h000);
        rd(1, "R2 masked");
        rd(0, "R2 mask readback");
        chk_irq("R9 irq high");
        // R3: single-source clear
        rd(CLR_B + 5, "R3 clear returns raw");
        rd(2, "R3 only bit5 cleared");
        // R7: level sources ignore clears
        set_lvl(12'h014);
        rd(2, "R7 level set");
        rd(CLR_B + 2, "R7 clear level");
        rd(2, "R7 level kept");
        set_lvl(12'h000);
        rd(2, "R7 level dropped");
        // R11 / R5: abort cause capture and clear
        pulse(12'h040, 12'h141);
        rd(3, "R11 bits 6 and 8 dropped");
        pulse('0, 12'hE00);
        rd(3, "R5 cause accumulates");
        rd(CLR_B + 6, "R5 abort clear");
        rd(3, "R5 cause wiped");
        rd(2, "R5 raw bit6 cleared");
        // R8: event beats a same-cycle clear
        rd_pulse(CLR_B + 9, 12'h200, "R8 colliding read");
        rd(2, "R8 bit9 kept");
        // R6: zero mask silences irq, raw untouched
        wr_reg(0, '0);
        chk_irq("R6 irq low");
        rd(2, "R6 raw unchanged");
        rd(1, "R6 masked zero");
        // R4: global clear
        pulse('0, 12'h003);
        set_lvl(12'h010);
        rd(CLR_ALL, "R4 global clear");
        rd(2, "R4 only level left");
        rd(3, "R4 cause cleared");
        set_lvl(12'h000);
        // R9: irq one cycle after raw
        wr_reg(0, 12'h001);
        @(negedge clk);
        evt_in = 12'h001;
        @(negedge clk);
        evt_in = '0;
        m_raw[0] = 1'b1;
        check("R9 irq not yet", {11'd0, irq}, '0);
        @(negedge clk);
        check("R9 irq raised", {11'd0, irq}, 12'h001);
        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", N'(exp_q.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule